// File: doc/BRIEF.md
# Strobe-Handshake Fall-Through FIFO

This block is a 64-word by 9-bit first-in first-out buffer driven by two level strobes rather than by clocked valid/ready signals. A producer raises `shift_in`, waits for the strobe to be seen, and lowers it. The word on `wr_data` is committed when the falling edge is detected. A consumer does the same with `shift_out`. Both strobes are brought through a two-stage synchronizer onto the system clock `clk`. Their rising and falling edges are found there, so a strobe edge takes effect at the third rising clock edge after it changes.

Storage is a RAM with separate write and read pointers. The output register always shows the oldest unread word, so the first word written into an empty buffer falls through to `rd_data` with no read request. Two status outputs together report empty, partly filled, more than half filled, and full.

A strobe raised while the buffer cannot serve it stays pending. A write held high against a full buffer completes on its own once a read frees a location. A read held high against an empty buffer consumes the next arriving word at once.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst_n` is low, and after it is released, `rd_data` is 0, `in_ready` is 1, `out_ready` is 0, and `occupied` and `over_half` are both 0.
- R2: `in_ready` drops while an accepted write strobe is high. The word on `wr_data` is stored at the strobe's detected falling edge, and `in_ready` then returns to 1 unless the buffer holds 64 words.
- R3: A write into an empty buffer puts that word on `rd_data` and raises `out_ready` when the write completes, even though `shift_out` is low.
- R4: A read strobe accepted with data present drops `out_ready`. At its falling edge the next stored word is presented. With no word left, `out_ready` stays 0 and `rd_data` keeps the last word read, including through further read strobes.
- R5: Words leave in the order they were written, and 64 words can be held at once.
- R6: `occupied` rises when the first write into an empty buffer completes. It falls at the rising edge of the write that will make 64 words, rises when the first read from a full buffer completes, and falls when the read that empties the buffer completes.
- R7: `over_half` rises at the rising edge of the 33rd write. It falls at the rising edge of the read that brings the count back to 32 or fewer. The code {occupied, over_half} is 00 empty, 10 1..32 words, 11 33..63 words, 01 full.
- R8: A write strobe that rises and falls while the buffer is full stores nothing, and `in_ready` stays 0.
- R9: A write strobe held high while full completes by itself after a read frees a location. `in_ready` and `occupied` each go high for exactly one clock cycle, and the buffer is full again.
- R10: A read strobe held high while empty consumes the next written word at once. `out_ready` and `occupied` each go high for exactly one cycle, `rd_data` keeps that word, and the buffer is empty again.
- R11: A write and a read completing in the same cycle leave the word count unchanged.
- R12: A strobe edge changes the outputs at the third rising `clk` edge after the strobe changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Master reset, active low, asserted asynchronously |
| shift_in | input | 1 | Write strobe (level pulse) |
| shift_out | input | 1 | Read strobe (level pulse) |
| wr_data | input | 9 | Word to be written |
| rd_data | output | 9 | Oldest unread word, or the last word read |
| in_ready | output | 1 | A write can be accepted |
| out_ready | output | 1 | A word is available to read |
| occupied | output | 1 | Status flag: neither empty nor full |
| over_half | output | 1 | Status flag: more than half full |

## Verification
The bench builds the block with its default depth of 64 words and width of 9 bits. This keeps the half-full boundary at the 33rd word and the full boundary at the 64th word, and both can be reached with a few hundred cycles of strobe pulses. It can therefore drive the held-write-against-full and held-read-against-empty cases at the real limits. A behavioural queue model runs alongside the block and is compared on every clock. Targeted checks add the one-cycle pulse widths, the synchronizer latency and the same-cycle write/read case.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } strobe_ev_t;
endpackage

// File: rtl/strobe_fifo_sync.sv
module strobe_fifo_sync #(
  parameter int STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lvl_in,
  output strobe_fifo_pkg::strobe_ev_t ev
);
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_n;

  assign chain_n = {chain_q[STAGES-1:0], lvl_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign ev.lvl  = chain_q[STAGES-1];
  assign ev.rise = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign ev.fall = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/strobe_fifo_ram.sv
module strobe_fifo_ram #(
  parameter int DW    = 9,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_word,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_word
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/strobe_fifo_ctrl.sv
module strobe_fifo_ctrl #(
  parameter int DW    = 9,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  strobe_fifo_pkg::strobe_ev_t si_ev,
  input  strobe_fifo_pkg::strobe_ev_t so_ev,
  input  logic [DW-1:0]               wr_data,
  input  logic [DW-1:0]               ahead_word,
  output logic                        wr_done,
  output logic                        rd_done,
  output logic [AW-1:0]               wr_ptr,
  output logic [AW-1:0]               ahead_ptr,
  output logic [CW-1:0]               occ,
  output logic [DW-1:0]               rd_data,
  output logic                        in_ready,
  output logic                        out_ready,
  output logic                        occupied,
  output logic                        over_half
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW:0]   FULL_EXT = (CW+1)'(DEPTH);
  localparam logic [CW:0]   HALF_EXT = (CW+1)'(DEPTH / 2);

  logic [AW-1:0] rd_ptr, wr_ptr_n, rd_ptr_n;
  logic [CW-1:0] occ_n;
  logic [DW-1:0] out_q, out_n;
  logic          pend_w, pend_w_n, hold_w, hold_w_n;
  logic          pend_r, pend_r_n, hold_r, hold_r_n;
  logic          full, empty, take_held_w, take_held_r, out_load;
  logic [CW:0]   fill_est;

  assign full        = (occ == FULL_CNT);
  assign empty       = (occ == '0);
  assign take_held_w = hold_w & ~full;
  assign take_held_r = hold_r & ~empty;
  assign wr_done     = (si_ev.fall & pend_w) | take_held_w;
  assign rd_done     = (so_ev.fall & pend_r) | take_held_r;
  assign ahead_ptr   = rd_ptr + 1'b1;

  always_comb begin
    pend_w_n = pend_w;
    hold_w_n = hold_w;
    if (si_ev.rise) begin
      pend_w_n = ~full;
      hold_w_n = full;
    end else if (si_ev.fall) begin
      pend_w_n = 1'b0;
      hold_w_n = 1'b0;
    end else if (take_held_w) begin
      hold_w_n = 1'b0;
    end

    pend_r_n = pend_r;
    hold_r_n = hold_r;
    if (so_ev.rise) begin
      pend_r_n = ~empty;
      hold_r_n = empty;
    end else if (so_ev.fall) begin
      pend_r_n = 1'b0;
      hold_r_n = 1'b0;
    end else if (take_held_r) begin
      hold_r_n = 1'b0;
    end

    wr_ptr_n = wr_ptr + AW'(wr_done);
    rd_ptr_n = rd_ptr + AW'(rd_done);
    occ_n    = occ + CW'(wr_done) - CW'(rd_done);

    out_load = 1'b0;
    out_n    = out_q;
    if (rd_done) begin
      if (occ > CW'(1)) begin
        out_load = 1'b1;
        out_n    = ahead_word;
      end else if (wr_done) begin
        out_load = 1'b1;
        out_n    = wr_data;
      end
    end else if (wr_done && empty) begin
      out_load = 1'b1;
      out_n    = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      pend_w <= 1'b0;
      hold_w <= 1'b0;
      pend_r <= 1'b0;
      hold_r <= 1'b0;
      out_q  <= '0;
    end else begin
      pend_w <= pend_w_n;
      hold_w <= hold_w_n;
      pend_r <= pend_r_n;
      hold_r <= hold_r_n;
      if (wr_done)            wr_ptr <= wr_ptr_n;
      if (rd_done)            rd_ptr <= rd_ptr_n;
      if (wr_done || rd_done) occ    <= occ_n;
      if (out_load)           out_q  <= out_n;
    end
  end

  assign fill_est  = {1'b0, occ} + {{CW{1'b0}}, pend_w} - {{CW{1'b0}}, pend_r};
  assign rd_data   = out_q;
  assign in_ready  = ~full & ~pend_w;
  assign out_ready = ~empty & ~pend_r;
  assign occupied  = ~empty & (({1'b0, occ} + {{CW{1'b0}}, pend_w}) != FULL_EXT);
  assign over_half = (fill_est > HALF_EXT);
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
  parameter int DW          = 9,
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_in,
  input  logic          shift_out,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          in_ready,
  output logic          out_ready,
  output logic          occupied,
  output logic          over_half
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  strobe_fifo_pkg::strobe_ev_t ev [2];
  logic [1:0] strobe_lvl;
  assign strobe_lvl = {shift_out, shift_in};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    strobe_fifo_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .lvl_in (strobe_lvl[g]),
      .ev     (ev[g])
    );
  end

  logic          wr_done, rd_done;
  logic [AW-1:0] wr_ptr, ahead_ptr;
  logic [CW-1:0] occ;
  logic [DW-1:0] ahead_word;

  strobe_fifo_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk     (clk),
    .wr_en   (wr_done),
    .wr_addr (wr_ptr),
    .wr_word (wr_data),
    .rd_addr (ahead_ptr),
    .rd_word (ahead_word)
  );

  strobe_fifo_ctrl #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .si_ev      (ev[0]),
    .so_ev      (ev[1]),
    .wr_data    (wr_data),
    .ahead_word (ahead_word),
    .wr_done    (wr_done),
    .rd_done    (rd_done),
    .wr_ptr     (wr_ptr),
    .ahead_ptr  (ahead_ptr),
    .occ        (occ),
    .rd_data    (rd_data),
    .in_ready   (in_ready),
    .out_ready  (out_ready),
    .occupied   (occupied),
    .over_half  (over_half)
  );
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_ready,
  input logic          occupied,
  input logic          over_half,
  input logic [CW-1:0] occ,
  input logic          wr_done,
  input logic          rd_done
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_state: assert (in_ready && !out_ready && !occupied && !over_half)
        else $error("R1 reset state wrong");
    end
  end

  a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CW'(DEPTH) && !rd_done) |=> (occ == CW'(DEPTH)));

  a_r11_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && rd_done) |=> $stable(occ));

  a_r7_full_code_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (over_half && !occupied) |-> !in_ready);

  a_r4_empty_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!occupied && !over_half) |-> !out_ready);
endmodule

bind strobe_fifo strobe_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .in_ready  (in_ready),
  .out_ready (out_ready),
  .occupied  (occupied),
  .over_half (over_half),
  .occ       (occ),
  .wr_done   (wr_done),
  .rd_done   (rd_done)
);

// File: tb/strobe_fifo_bench.sv
module strobe_fifo_bench;
  localparam int DW = 9;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic si = 1'b0, so = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic in_rdy, out_rdy, f_occ, f_half;

  strobe_fifo u_strobe_fifo (
    .clk(clk), .rst_n(rst_n), .shift_in(si), .shift_out(so), .wr_data(din),
    .rd_data(dout), .in_ready(in_rdy), .out_ready(out_rdy),
    .occupied(f_occ), .over_half(f_half)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit run = 0, done = 0;

  // behavioural reference
  int q[$];
  int md, pw, pr, sh, oh;
  int a1, a2, a3, b1, b2, b3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); md = 0; pw = 0; pr = 0; sh = 0; oh = 0;
      a1 = 0; a2 = 0; a3 = 0; b1 = 0; b2 = 0; b3 = 0;
    end else begin
      int ri, fi, ro, fo, wd, rd, full, empty;
      ri = a2 && !a3; fi = !a2 && a3;
      ro = b2 && !b3; fo = !b2 && b3;
      full = (q.size() == DEPTH); empty = (q.size() == 0);
      wd = (fi && pw) || (sh && !full);
      rd = (fo && pr) || (oh && !empty);
      if (rd) begin
        if (q.size() >= 2) md = q[1];
        else if (wd) md = din;
      end else if (wd && empty) md = din;
      if (rd) void'(q.pop_front());
      if (wd) q.push_back(int'(din));
      if (ri) begin pw = !full; sh = full; end
      else if (fi) begin pw = 0; sh = 0; end
      else if (sh && !full) sh = 0;
      if (ro) begin pr = !empty; oh = empty; end
      else if (fo) begin pr = 0; oh = 0; end
      else if (oh && !empty) oh = 0;
      a3 = a2; a2 = a1; a1 = si;
      b3 = b2; b2 = b1; b1 = so;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      int n;
      n = q.size();
      chk("R5 rd_data", int'(dout), md);
      chk("R2 in_ready", int'(in_rdy), (n != DEPTH && !pw) ? 1 : 0);
      chk("R4 out_ready", int'(out_rdy), (n != 0 && !pr) ? 1 : 0);
      chk("R6 occupied", int'(f_occ), (n != 0 && (n + pw) != DEPTH) ? 1 : 0);
      chk("R7 over_half", int'(f_half), ((n + pw - pr) > DEPTH / 2) ? 1 : 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(int v);
    din = DW'(v); si = 1'b1; wait_n(4);
    si = 1'b0; wait_n(4);
  endtask

  task automatic take();
    so = 1'b1; wait_n(4);
    so = 1'b0; wait_n(4);
  endtask

  initial begin
    int hi_a, hi_b, got, keep;
    wait_n(3);
    chk("R1 reset rd_data", int'(dout), 0);
    chk("R1 reset in_ready", int'(in_rdy), 1);
    chk("R1 reset out_ready", int'(out_rdy), 0);
    chk("R1 reset flags", int'({f_occ, f_half}), 0);
    rst_n = 1'b1;
    wait_n(4);
    run = 1;
    chk("R1 after release", int'({in_rdy, out_rdy, f_occ, f_half}), 4'b1000);

    // R12: latency of the write strobe; R3: fall-through into empty
    din = 9'h15A; si = 1'b1;
    wait_n(2);
    chk("R12 in_ready before third edge", int'(in_rdy), 1);
    wait_n(1);
    chk("R12 in_ready after third edge", int'(in_rdy), 0);
    wait_n(1);
    si = 1'b0; wait_n(2);
    chk("R12 out_ready before third edge", int'(out_rdy), 0);
    wait_n(1);
    chk("R3 fall-through out_ready", int'(out_rdy), 1);
    chk("R3 fall-through word", int'(dout), 'h15A);
    chk("R6 occupied after first write", int'({f_occ, f_half}), 2'b10);
    wait_n(2);

    // fill to 64 with distinct words; R7 at the 33rd
    for (int i = 1; i < DEPTH; i++) begin
      if (i == 32) begin
        chk("R7 32 words code 10", int'({f_occ, f_half}), 2'b10);
        din = DW'(i * 7); si = 1'b1; wait_n(3);
        chk("R7 33rd write rising", int'({f_occ, f_half}), 2'b11);
        wait_n(1); si = 1'b0; wait_n(4);
      end else put(i * 7);
    end
    chk("R7 full code 01", int'({f_occ, f_half}), 2'b01);
    chk("R8 full in_ready", int'(in_rdy), 0);

    // R8: write while full ignored
    keep = int'(dout);
    put(9'h0FF);
    chk("R8 ignored write keeps head", int'(dout), keep);
    chk("R8 ignored write keeps full code", int'({f_occ, f_half}), 2'b01);
    chk("R8 ignored write in_ready", int'(in_rdy), 0);

    // R9: held write against full
    din = 9'h1AA; si = 1'b1; wait_n(6);
    so = 1'b1; wait_n(4); so = 1'b0;
    hi_a = 0; hi_b = 0;
    for (int k = 0; k < 10; k++) begin
      wait_n(1);
      hi_a += int'(in_rdy); hi_b += int'(f_occ);
    end
    chk("R9 in_ready pulse cycles", hi_a, 1);
    chk("R9 occupied pulse cycles", hi_b, 1);
    chk("R9 full again", int'({f_occ, f_half}), 2'b01);
    si = 1'b0; wait_n(4);

    // drain everything (order checked by the reference each cycle)
    for (int i = 0; i < DEPTH; i++) take();
    chk("R6 empty after drain", int'({f_occ, f_half}), 2'b00);
    chk("R5 last word out", int'(dout), 'h1AA);
    keep = int'(dout);
    take();
    chk("R4 read on empty keeps word", int'(dout), keep);
    chk("R4 read on empty out_ready", int'(out_rdy), 0);

    // R10: held read against empty
    so = 1'b1; wait_n(6);
    din = 9'h0C3; si = 1'b1; wait_n(4); si = 1'b0;
    hi_a = 0; hi_b = 0;
    for (int k = 0; k < 10; k++) begin
      wait_n(1);
      hi_a += int'(out_rdy); hi_b += int'(f_occ);
    end
    chk("R10 out_ready pulse cycles", hi_a, 1);
    chk("R10 occupied pulse cycles", hi_b, 1);
    chk("R10 word kept", int'(dout), 'h0C3);
    chk("R10 empty again", int'({f_occ, f_half}), 2'b00);
    so = 1'b0; wait_n(4);

    // R11: write and read completing in the same cycle
    for (int i = 0; i < 5; i++) put(40 + i);
    din = 9'h077; si = 1'b1; so = 1'b1; wait_n(4);
    si = 1'b0; so = 1'b0; wait_n(5);
    got = 0;
    while (out_rdy && got < 20) begin take(); got++; end
    chk("R11 words after overlap", got, 5);

    run = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule